// File: doc/BRIEF.md
# Multicycle Load/Store Datapath

This block is the datapath of a small 32-bit processor that carries out each instruction as a chain of single-cycle register transfers. It handles five instruction kinds: register-register ALU operations, OR with an unsigned immediate, word load, word store and branch on equality. The datapath holds a program counter, an instruction register, two operand latches (A, B), an equality flag (E), an ALU result latch (S) and a memory data latch (M). It also holds a 32-entry register file and two word-addressed memories, one for instructions and one for data.

The datapath contains no sequencer. Every latch enable and every multiplexer select is an input port, so an external controller or a testbench chooses which transfer commits on each rising edge. Depending on its kind, an instruction takes three to five such steps. A preload port writes words into either memory before a program runs. Outputs show the program counter and all the internal latches, so each step can be observed.

Top module: `mc_datapath`

## Requirements
- R1: While rst_ni is low, pc_o, ir_o, a_o, b_o, e_o, s_o and m_o all read zero.
- R2: When ir_en_i is high, the next edge loads IR with the instruction-memory word at index pc_o[7:2]. When ir_en_i is low, ir_o holds its value.
- R3: When ab_en_i is high, A and B take the register values selected by IR bits [25:21] and [20:16]. When e_en_i is high, E takes 1 if those two register values are equal and 0 otherwise.
- R4: When s_en_i is high, S loads a value chosen by s_sel_i. With s_sel_i=2, S is A plus the sign-extended IR[15:0]. With s_sel_i=1, S is A OR the zero-extended IR[15:0]. With s_sel_i=0, S is the ALU result, selected by IR[5:0]: 0x20 add, 0x22 subtract A minus B, 0x24 AND, 0x25 OR, 0x2A signed less-than (1 or 0). Any other function code gives 0.
- R5: When m_en_i is high, M loads the data-memory word at index S[7:2].
- R6: When dmem_wr_i is high, B is written to the data-memory word at index S[7:2]. A later load from that address returns it.
- R7: When reg_wr_i is high, the register file writes one register. The destination is IR[15:11] if reg_dst_i is 1, otherwise IR[20:16]. The data is M if mem_to_reg_i is 1, otherwise S.
- R8: Register 0 always reads zero. A write to register 0 has no effect.
- R9: When pc_en_i is high, the PC advances by 4. The exception is when pc_sel_i and E are both 1: then the PC becomes PC+4 plus the sign-extended IR[15:0] shifted left by two. When pc_en_i is low, the PC holds.
- R10: If a register write and an A/B load fall on the same edge, A and B capture the register value from before the write. A later load sees the new value.
- R11: When ld_en_i is high, ld_data_i is written at word index ld_addr_i. The target is the instruction memory if ld_sel_i is 0 and the data memory if ld_sel_i is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_en_i | input | 1 | Preload write strobe |
| ld_sel_i | input | 1 | Preload target: 0 instruction memory, 1 data memory |
| ld_addr_i | input | 6 | Preload word index |
| ld_data_i | input | 32 | Preload word |
| ir_en_i | input | 1 | Load instruction register |
| ab_en_i | input | 1 | Load operand latches A and B |
| e_en_i | input | 1 | Load equality flag |
| s_en_i | input | 1 | Load result latch S |
| s_sel_i | input | 2 | S source: 0 ALU function, 1 OR immediate, 2 add immediate |
| m_en_i | input | 1 | Load memory data latch M |
| dmem_wr_i | input | 1 | Write B to data memory at S |
| reg_wr_i | input | 1 | Register file write |
| reg_dst_i | input | 1 | Destination field: 0 IR[20:16], 1 IR[15:11] |
| mem_to_reg_i | input | 1 | Write data: 0 S, 1 M |
| pc_en_i | input | 1 | Update program counter |
| pc_sel_i | input | 1 | 1 selects the branch target when E is set |
| pc_o | output | 32 | Program counter |
| ir_o | output | 32 | Instruction register |
| a_o | output | 32 | Operand latch A |
| b_o | output | 32 | Operand latch B |
| e_o | output | 1 | Equality flag |
| s_o | output | 32 | Result latch S |
| m_o | output | 32 | Memory data latch M |

## Verification
The write-back of one instruction can share an edge with an operand fetch that reads the same register. The bench provokes this with an OR-immediate whose source and destination registers are the same. It raises the write-back and the A/B load together and checks that A captures the old value. One idle cycle later, a second A/B load must return the written value. The branch update and the PC hold are also covered, with both a taken and a not-taken equality branch.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int XLEN  = 32;
  localparam int RA_W  = 5;
  localparam int NREGS = 1 << RA_W;

  typedef enum logic [1:0] {
    SSRC_FUNCT = 2'd0,
    SSRC_ORI   = 2'd1,
    SSRC_ADDI  = 2'd2
  } s_src_e;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;
endpackage

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
(
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [5:0]      fn_i,
  output logic [XLEN-1:0] y_o
);
  always_comb begin
    unique case (fn_i)
      FN_ADD:  y_o = a_i + b_i;
      FN_SUB:  y_o = a_i - b_i;
      FN_AND:  y_o = a_i & b_i;
      FN_OR:   y_o = a_i | b_i;
      FN_SLT:  y_o = {{(XLEN-1){1'b0}}, ($signed(a_i) < $signed(b_i))};
      default: y_o = '0;
    endcase
  end
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile
  import mc_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [RA_W-1:0] ra1_i,
  input  logic [RA_W-1:0] ra2_i,
  input  logic            we_i,
  input  logic [RA_W-1:0] wa_i,
  input  logic [XLEN-1:0] wd_i,
  output logic [XLEN-1:0] rd1_o,
  output logic [XLEN-1:0] rd2_o
);
  logic [XLEN-1:0] regs_q [NREGS];

  // entry 0 is never stored
  assign regs_q[0] = '0;

  for (genvar g = 1; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      regs_q[g] <= '0;
      else if (we_i && wa_i == RA_W'(g)) regs_q[g] <= wd_i;
    end
  end

  assign rd1_o = regs_q[ra1_i];
  assign rd2_o = regs_q[ra2_i];
endmodule

// File: rtl/mc_mem.sv
module mc_mem #(
  parameter int W     = 32,
  parameter int WORDS = 64,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  logic [W-1:0]     wdata_i,
  input  logic [IDX_W-1:0] raddr_i,
  output logic [W-1:0]     rdata_o
);
  logic [W-1:0] mem_q [WORDS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
  import mc_pkg::*;
#(
  parameter int MEM_WORDS = 64,
  localparam int IDX_W = $clog2(MEM_WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_en_i,
  input  logic             ld_sel_i,
  input  logic [IDX_W-1:0] ld_addr_i,
  input  logic [XLEN-1:0]  ld_data_i,
  input  logic             ir_en_i,
  input  logic             ab_en_i,
  input  logic             e_en_i,
  input  logic             s_en_i,
  input  logic [1:0]       s_sel_i,
  input  logic             m_en_i,
  input  logic             dmem_wr_i,
  input  logic             reg_wr_i,
  input  logic             reg_dst_i,
  input  logic             mem_to_reg_i,
  input  logic             pc_en_i,
  input  logic             pc_sel_i,
  output logic [XLEN-1:0]  pc_o,
  output logic [XLEN-1:0]  ir_o,
  output logic [XLEN-1:0]  a_o,
  output logic [XLEN-1:0]  b_o,
  output logic             e_o,
  output logic [XLEN-1:0]  s_o,
  output logic [XLEN-1:0]  m_o
);
  logic [XLEN-1:0] pc_q, ir_q, a_q, b_q, s_q, m_q;
  logic            e_q;

  logic [XLEN-1:0] imem_rd, dmem_rd, rf_rd1, rf_rd2, alu_y;
  logic [XLEN-1:0] imm_sx, imm_zx, s_d, pc_inc, pc_br, pc_d;
  logic [XLEN-1:0] rf_wd, dm_wd;
  logic [RA_W-1:0] rf_wa;
  logic [IDX_W-1:0] dm_wa;
  logic            dm_we;

  // preload port has priority over a store on the same edge
  assign dm_we = dmem_wr_i | (ld_en_i & ld_sel_i);
  assign dm_wa = (ld_en_i && ld_sel_i) ? ld_addr_i : s_q[IDX_W+1:2];
  assign dm_wd = (ld_en_i && ld_sel_i) ? ld_data_i : b_q;

  mc_mem #(.W(XLEN), .WORDS(MEM_WORDS)) u_imem (
    .clk_i   (clk_i),
    .we_i    (ld_en_i & ~ld_sel_i),
    .waddr_i (ld_addr_i),
    .wdata_i (ld_data_i),
    .raddr_i (pc_q[IDX_W+1:2]),
    .rdata_o (imem_rd)
  );

  mc_mem #(.W(XLEN), .WORDS(MEM_WORDS)) u_dmem (
    .clk_i   (clk_i),
    .we_i    (dm_we),
    .waddr_i (dm_wa),
    .wdata_i (dm_wd),
    .raddr_i (s_q[IDX_W+1:2]),
    .rdata_o (dmem_rd)
  );

  assign rf_wa = reg_dst_i ? ir_q[15:11] : ir_q[20:16];
  assign rf_wd = mem_to_reg_i ? m_q : s_q;

  mc_regfile u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ra1_i  (ir_q[25:21]),
    .ra2_i  (ir_q[20:16]),
    .we_i   (reg_wr_i),
    .wa_i   (rf_wa),
    .wd_i   (rf_wd),
    .rd1_o  (rf_rd1),
    .rd2_o  (rf_rd2)
  );

  mc_alu u_alu (
    .a_i  (a_q),
    .b_i  (b_q),
    .fn_i (ir_q[5:0]),
    .y_o  (alu_y)
  );

  assign imm_sx = {{(XLEN-16){ir_q[15]}}, ir_q[15:0]};
  assign imm_zx = {{(XLEN-16){1'b0}}, ir_q[15:0]};

  always_comb begin
    unique case (s_src_e'(s_sel_i))
      SSRC_ORI:  s_d = a_q | imm_zx;
      SSRC_ADDI: s_d = a_q + imm_sx;
      default:   s_d = alu_y;
    endcase
  end

  assign pc_inc = pc_q + XLEN'(4);
  assign pc_br  = pc_inc + {imm_sx[XLEN-3:0], 2'b00};
  assign pc_d   = (pc_sel_i && e_q) ? pc_br : pc_inc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0;
      ir_q <= '0;
      a_q  <= '0;
      b_q  <= '0;
      e_q  <= 1'b0;
      s_q  <= '0;
      m_q  <= '0;
    end else begin
      if (pc_en_i) pc_q <= pc_d;
      if (ir_en_i) ir_q <= imem_rd;
      if (ab_en_i) begin
        a_q <= rf_rd1;
        b_q <= rf_rd2;
      end
      if (e_en_i)  e_q <= (rf_rd1 == rf_rd2);
      if (s_en_i)  s_q <= s_d;
      if (m_en_i)  m_q <= dmem_rd;
    end
  end

  assign pc_o = pc_q;
  assign ir_o = ir_q;
  assign a_o  = a_q;
  assign b_o  = b_q;
  assign e_o  = e_q;
  assign s_o  = s_q;
  assign m_o  = m_q;
endmodule

// File: rtl/mc_datapath_chk.sv
module mc_datapath_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        ir_en_i,
  input logic        s_en_i,
  input logic [1:0]  s_sel_i,
  input logic        pc_en_i,
  input logic        pc_sel_i,
  input logic [31:0] pc_o,
  input logic [31:0] ir_o,
  input logic [31:0] a_o,
  input logic        e_o,
  input logic [31:0] s_o
);
  a_r2_ir_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ir_en_i |=> $stable(ir_o));

  a_r9_pc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pc_en_i |=> $stable(pc_o));

  a_r9_pc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_en_i && !(pc_sel_i && e_o)) |=> pc_o == $past(pc_o) + 32'd4);

  a_r9_pc_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_en_i && pc_sel_i && e_o) |=>
      pc_o == $past(pc_o) + 32'd4 + {{14{$past(ir_o[15])}}, $past(ir_o[15:0]), 2'b00});

  a_r9_pc_align: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_o[1:0] == 2'b00);

  a_r4_ori: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_en_i && s_sel_i == 2'd1) |=> s_o == ($past(a_o) | {16'd0, $past(ir_o[15:0])}));
endmodule

bind mc_datapath mc_datapath_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ir_en_i  (ir_en_i),
  .s_en_i   (s_en_i),
  .s_sel_i  (s_sel_i),
  .pc_en_i  (pc_en_i),
  .pc_sel_i (pc_sel_i),
  .pc_o     (pc_o),
  .ir_o     (ir_o),
  .a_o      (a_o),
  .e_o      (e_o),
  .s_o      (s_o)
);

// File: tb/tb_mc_datapath.sv
module tb_mc_datapath;
  localparam int IDX_W = 6;
  localparam int WORDS = 64;

  localparam int O_PC = 0, O_IR = 1, O_A = 2, O_B = 3, O_E = 4, O_S = 5, O_M = 6;

  typedef struct {
    string       req;
    int          sel;
    logic [31:0] exp;
  } sb_item_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ld_en = 0, ld_sel = 0;
  logic [IDX_W-1:0] ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic ir_en = 0, ab_en = 0, e_en = 0, s_en = 0, m_en = 0, dmem_wr = 0;
  logic reg_wr = 0, reg_dst = 0, mem_to_reg = 0, pc_en = 0, pc_sel = 0;
  logic [1:0] s_sel = '0;
  logic [31:0] pc_o, ir_o, a_o, b_o, s_o, m_o;
  logic e_o;

  always #2.5 clk = ~clk;

  mc_datapath dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .ld_en_i(ld_en), .ld_sel_i(ld_sel), .ld_addr_i(ld_addr), .ld_data_i(ld_data),
    .ir_en_i(ir_en), .ab_en_i(ab_en), .e_en_i(e_en), .s_en_i(s_en), .s_sel_i(s_sel),
    .m_en_i(m_en), .dmem_wr_i(dmem_wr), .reg_wr_i(reg_wr), .reg_dst_i(reg_dst),
    .mem_to_reg_i(mem_to_reg), .pc_en_i(pc_en), .pc_sel_i(pc_sel),
    .pc_o(pc_o), .ir_o(ir_o), .a_o(a_o), .b_o(b_o), .e_o(e_o), .s_o(s_o), .m_o(m_o)
  );

  sb_item_t sb[$];
  int n_run = 0, n_fail = 0;
  bit done = 0;

  // reference state
  logic [31:0] m_imem [WORDS];
  logic [31:0] m_dmem [WORDS];
  logic [31:0] m_rf [32];
  logic [31:0] m_pc, m_ir, m_a, m_b, m_s, m_m;
  logic        m_e;

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  function automatic logic [31:0] prog(int i);
    case (i)
      0:  return enc_i(6'h0D, 0, 1, 16'h00F0);
      1:  return enc_i(6'h0D, 0, 2, 16'h8001);
      2:  return enc_r(1, 2, 3, 6'h20);
      3:  return enc_r(1, 2, 4, 6'h22);
      4:  return enc_r(1, 2, 6, 6'h24);
      5:  return enc_r(1, 2, 7, 6'h25);
      6:  return enc_r(4, 1, 5, 6'h2A);
      7:  return enc_i(6'h2B, 1, 3, 16'hFFF0);
      8:  return enc_i(6'h23, 1, 8, 16'hFFF0);
      9:  return enc_i(6'h04, 3, 8, 16'h0003);
      10, 11, 12: return 32'hFFFF_FFFF;
      13: return enc_i(6'h04, 1, 2, 16'h0005);
      14: return enc_i(6'h0D, 1, 0, 16'h0005);
      15: return enc_r(0, 1, 9, 6'h20);
      16: return enc_i(6'h0D, 1, 1, 16'h0F00);
      17: return enc_r(1, 2, 11, 6'h3F);
      18: return enc_r(5, 4, 12, 6'h20);
      19: return enc_r(7, 6, 13, 6'h20);
      20: return enc_i(6'h23, 0, 14, 16'h0014);
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [31:0] ref_alu(logic [31:0] a, logic [31:0] b, logic [5:0] fn);
    case (fn)
      6'h20: return a + b;
      6'h22: return a - b;
      6'h24: return a & b;
      6'h25: return a | b;
      6'h2A: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [31:0] outv(int sel);
    case (sel)
      O_PC: return pc_o;
      O_IR: return ir_o;
      O_A:  return a_o;
      O_B:  return b_o;
      O_E:  return {31'd0, e_o};
      O_S:  return s_o;
      default: return m_o;
    endcase
  endfunction

  task automatic expect_out(string req, int sel, logic [31:0] exp);
    sb_item_t it;
    it.req = req; it.sel = sel; it.exp = exp;
    sb.push_back(it);
  endtask

  // monitor: judges pending items half a cycle after the committing edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      sb_item_t it;
      logic [31:0] got;
      it = sb.pop_front();
      got = outv(it.sel);
      n_run++;
      if (got !== it.exp) begin
        n_fail++;
        $display("FAIL %s out%0d got %h exp %h", it.req, it.sel, got, it.exp);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
    {ld_en, ld_sel, ir_en, ab_en, e_en, s_en, m_en, dmem_wr} = '0;
    {reg_wr, reg_dst, mem_to_reg, pc_en, pc_sel} = '0;
    s_sel = '0;
  endtask

  function automatic logic [31:0] rrd(logic [4:0] idx);
    return (idx == 0) ? 32'd0 : m_rf[idx];
  endfunction

  task automatic do_fetch();
    ir_en = 1; tick();
    m_ir = m_imem[m_pc[7:2]];
    expect_out("R2", O_IR, m_ir);
  endtask

  task automatic do_decode();
    ab_en = 1; e_en = 1; tick();
    m_a = rrd(m_ir[25:21]); m_b = rrd(m_ir[20:16]); m_e = (m_a == m_b);
    expect_out("R3/R8", O_A, m_a);
    expect_out("R3/R8", O_B, m_b);
    expect_out("R3", O_E, {31'd0, m_e});
  endtask

  task automatic do_exec(logic [1:0] sel);
    s_en = 1; s_sel = sel; tick();
    case (sel)
      2'd1:    m_s = m_a | {16'd0, m_ir[15:0]};
      2'd2:    m_s = m_a + {{16{m_ir[15]}}, m_ir[15:0]};
      default: m_s = ref_alu(m_a, m_b, m_ir[5:0]);
    endcase
    expect_out("R4", O_S, m_s);
  endtask

  task automatic do_mem_rd();
    m_en = 1; tick();
    m_m = m_dmem[m_s[7:2]];
    expect_out("R5", O_M, m_m);
  endtask

  task automatic do_wb(bit use_rd, bit from_m, bit also_ab);
    logic [4:0] wa;
    reg_wr = 1; reg_dst = use_rd; mem_to_reg = from_m; pc_en = 1;
    ab_en = also_ab;
    tick();
    if (also_ab) begin
      m_a = rrd(m_ir[25:21]); m_b = rrd(m_ir[20:16]);
      expect_out("R10", O_A, m_a);
    end
    wa = use_rd ? m_ir[15:11] : m_ir[20:16];
    if (wa != 0) m_rf[wa] = from_m ? m_m : m_s;
    m_pc = m_pc + 4;
    expect_out("R7/R9", O_PC, m_pc);
  endtask

  task automatic do_store();
    dmem_wr = 1; pc_en = 1; tick();
    m_dmem[m_s[7:2]] = m_b;
    m_pc = m_pc + 4;
    expect_out("R6/R9", O_PC, m_pc);
  endtask

  task automatic do_branch();
    pc_en = 1; pc_sel = 1; tick();
    m_pc = m_e ? (m_pc + 4 + {{14{m_ir[15]}}, m_ir[15:0], 2'b00}) : (m_pc + 4);
    expect_out("R9", O_PC, m_pc);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) m_rf[i] = '0;
    for (int i = 0; i < WORDS; i++) begin m_imem[i] = prog(i); m_dmem[i] = '0; end
    {m_pc, m_ir, m_a, m_b, m_s, m_m} = '0;
    m_e = 0;

    // R1: reset state
    #4;
    expect_out("R1", O_PC, 32'd0); expect_out("R1", O_IR, 32'd0);
    expect_out("R1", O_A, 32'd0);  expect_out("R1", O_B, 32'd0);
    expect_out("R1", O_E, 32'd0);  expect_out("R1", O_S, 32'd0);
    expect_out("R1", O_M, 32'd0);
    @(posedge clk); @(posedge clk); #1;
    rst_ni = 1;

    // R11: preload both memories
    for (int i = 0; i < WORDS; i++) begin
      ld_en = 1; ld_sel = 0; ld_addr = IDX_W'(i); ld_data = m_imem[i]; tick();
    end
    for (int i = 0; i < WORDS; i++) begin
      ld_en = 1; ld_sel = 1; ld_addr = IDX_W'(i);
      ld_data = (i == 5) ? 32'hCAFE_F00D : 32'd0; tick();
      m_dmem[i] = ld_data;
    end
    expect_out("R9", O_PC, 32'd0);

    // ori r1, ori r2 (zero extension)
    for (int k = 0; k < 2; k++) begin do_fetch(); do_decode(); do_exec(2'd1); do_wb(0, 0, 0); end
    // add, sub, and, or, slt
    for (int k = 0; k < 5; k++) begin do_fetch(); do_decode(); do_exec(2'd0); do_wb(1, 0, 0); end
    // store then load of the same word
    do_fetch(); do_decode(); do_exec(2'd2); do_store();
    do_fetch(); do_decode(); do_exec(2'd2); do_mem_rd(); do_wb(0, 1, 0);
    // taken branch (r3 == r8), then not-taken branch (r1 != r2)
    do_fetch(); do_decode(); do_branch();
    expect_out("R9", O_PC, 32'd52);
    do_fetch(); do_decode(); do_branch();
    expect_out("R9", O_PC, 32'd56);
    // R8: write to r0 is dropped, r0 reads zero
    do_fetch(); do_decode(); do_exec(2'd1); do_wb(0, 0, 0);
    do_fetch(); do_decode();
    expect_out("R8", O_A, 32'd0);
    do_exec(2'd0); do_wb(1, 0, 0);
    // R10: write-back and operand load on one edge
    do_fetch(); do_decode(); do_exec(2'd1); do_wb(0, 0, 1);
    expect_out("R10", O_A, 32'h0000_00F0);
    ab_en = 1; tick();
    m_a = rrd(m_ir[25:21]);
    expect_out("R10", O_A, 32'h0000_0FF0);
    // unknown funct gives 0
    do_fetch(); do_decode(); do_exec(2'd0);
    expect_out("R4", O_S, 32'd0);
    do_wb(1, 0, 0);
    // read back slt/sub and and/or results
    do_fetch(); do_decode();
    expect_out("R7", O_A, 32'd1);
    do_exec(2'd0); do_wb(1, 0, 0);
    do_fetch(); do_decode(); do_exec(2'd0);
    expect_out("R7", O_S, 32'h0000_80F1);
    do_wb(1, 0, 0);
    // R11: load of a preloaded data word
    do_fetch(); do_decode(); do_exec(2'd2); do_mem_rd();
    expect_out("R11", O_M, 32'hCAFE_F00D);
    do_wb(0, 1, 0);
    // idle cycle: nothing moves
    tick();
    expect_out("R2", O_IR, m_ir);
    expect_out("R9", O_PC, m_pc);

    @(negedge clk); #1;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule